// File: doc/BRIEF.md
# Consumer IR Receive Sampler

This block turns a demodulated infrared input into a byte stream that software can read. On every sample tick it looks at the input and extends the current run of carrier-on ("pulse") or carrier-off ("space") time. When the polarity changes, or when a run reaches the largest count a byte can hold, it writes a byte holding the polarity and the run length into a 32-entry receive FIFO. A programmable idle limit ends a packet: once the input has stayed in space for that many ticks, the encoder writes out the space run it holds and raises a packet-end flag. It then ignores further space until the next pulse.

A small byte-wide register port gives access to control, sticky status, interrupt enables, FIFO level, FIFO data, FIFO control and the two bytes of the idle limit. Status bits are cleared by writing ones to them. The interrupt output is the OR of the status bits whose enable bit is set.

Register offsets: 0 control, 1 status, 2 interrupt enable, 3 FIFO level, 4 FIFO data, 5 FIFO control, 6 idle limit high byte, 7 idle limit low byte. A read strobe latches the addressed register into `reg_rdata`, which is valid from the next clock cycle onward.

Top module: `cir_rx_sampler`

## Requirements
- R1: Each byte written to the FIFO has bit 7 set for a pulse run and clear for a space run. Bits 6:0 hold the run length in ticks and are never zero.
- R2: A run longer than 127 ticks is written as 0x7F bytes of its polarity, one per 127 ticks, followed by a byte for the remainder when the remainder is non-zero.
- R3: When consecutive space ticks reach the 16-bit idle limit (high byte at offset 6, low byte at offset 7), the space run held is written out in the clock cycle after that tick and status bit 5 (packet end) is set. Space ticks before the first pulse, and after a packet end, produce no bytes. A limit of 0 disables packet end.
- R4: Control bit 0 enables sampling. While it is clear, ticks are ignored and the encoder returns to idle. With control bit 1 set, a low input is taken as a pulse.
- R5: The status register holds bit 7 data ready, bit 6 trigger level reached, bit 5 packet end and bit 4 overrun. Bits 3:0 read 0. Writing a 1 to a bit clears it; a new set event in the same cycle wins.
- R6: `irq` is high one cycle after any status bit whose matching bit in the enable register (offset 2, same layout) is set, and is low otherwise.
- R7: A byte arriving while the FIFO holds 32 bytes is dropped, sets overrun (bit 4) together with data ready (bit 7), and the level stays at 32.
- R8: The level register (offset 3) reports the number of bytes held. A read of offset 4 returns the oldest byte and removes it. A read of offset 4 on an empty FIFO returns 0.
- R9: Writing FIFO control (offset 5) with bit 7 set empties the FIFO; bit 7 reads back 0. Bits 1:0 select the trigger level as 1, 8, 16 or 24 bytes for codes 0 to 3. Bit 6 of status is set by a push that brings the level to or above the trigger level.
- R10: Every byte the encoder produces, stored or dropped, sets data ready (bit 7).
- R11: After reset every register reads 0, the FIFO is empty and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops FIFO at offset 4) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data, valid the cycle after the strobe |
| ir_in | input | 1 | Demodulated IR input level |
| tick_en | input | 1 | One-cycle sample tick |
| irq | output | 1 | Interrupt request |

## Verification
The checks assume `tick_en` never stays high for two cycles in a row. The cycle after a tick that ends a packet is reserved for writing out the pending space byte. The bench therefore spaces ticks four clock cycles apart. It also never flushes the FIFO in the same cycle as an encoder push, because it only writes FIFO control while ticks are stopped. The input level changes only between ticks, and register strobes last one cycle each.

// File: rtl/cirx_pkg.sv
package cirx_pkg;
  localparam int ADDR_W   = 3;
  localparam int LEN_W    = 7;
  localparam int BYTE_W   = LEN_W + 1;

  localparam logic [ADDR_W-1:0] RG_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] RG_STAT  = 3'd1;
  localparam logic [ADDR_W-1:0] RG_IEN   = 3'd2;
  localparam logic [ADDR_W-1:0] RG_LEVEL = 3'd3;
  localparam logic [ADDR_W-1:0] RG_DATA  = 3'd4;
  localparam logic [ADDR_W-1:0] RG_FCTL  = 3'd5;
  localparam logic [ADDR_W-1:0] RG_LIMH  = 3'd6;
  localparam logic [ADDR_W-1:0] RG_LIML  = 3'd7;

  localparam int ST_RDR = 7;
  localparam int ST_RTR = 6;
  localparam int ST_PE  = 5;
  localparam int ST_RFO = 4;
endpackage

// File: rtl/cirx_runlen.sv
module cirx_runlen #(
  parameter int LIMIT_W = 16,
  parameter int LEN_W   = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               invert,
  input  logic               tick,
  input  logic               ir_in,
  input  logic [LIMIT_W-1:0] limit,
  output logic               push_v,
  output logic [LEN_W:0]     push_byte,
  output logic               pkt_end
);
  localparam logic [LEN_W-1:0] MAX_LEN = {LEN_W{1'b1}};

  logic               smp;
  logic               pol_q;
  logic [LEN_W-1:0]   cnt_q;
  logic               quiet_q;
  logic               flush_q;
  logic [LIMIT_W-1:0] space_q;
  logic [LIMIT_W-1:0] space_nxt;

  assign smp       = ir_in ^ invert;
  assign space_nxt = space_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pol_q     <= 1'b0;
      cnt_q     <= '0;
      quiet_q   <= 1'b1;
      flush_q   <= 1'b0;
      space_q   <= '0;
      push_v    <= 1'b0;
      push_byte <= '0;
      pkt_end   <= 1'b0;
    end else begin
      push_v  <= 1'b0;
      pkt_end <= 1'b0;
      if (flush_q) begin
        // write out the held space run after the limit tick
        flush_q <= 1'b0;
        if (cnt_q != '0) begin
          push_v    <= 1'b1;
          push_byte <= {1'b0, cnt_q};
        end
        cnt_q   <= '0;
        quiet_q <= 1'b1;
        pkt_end <= 1'b1;
      end else if (tick) begin
        if (quiet_q) begin
          if (smp) begin
            quiet_q <= 1'b0;
            pol_q   <= 1'b1;
            cnt_q   <= 1;
            space_q <= '0;
          end
        end else begin
          if (smp == pol_q) begin
            if (cnt_q == MAX_LEN) begin
              push_v    <= 1'b1;
              push_byte <= {pol_q, MAX_LEN};
              cnt_q     <= 1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end else begin
            push_v    <= 1'b1;
            push_byte <= {pol_q, cnt_q};
            pol_q     <= smp;
            cnt_q     <= 1;
          end
          if (smp) begin
            space_q <= '0;
          end else begin
            space_q <= space_nxt;
            if (limit != '0 && space_nxt == limit) flush_q <= 1'b1;
          end
        end
      end
    end
  end

  // R1: an emitted run length is never zero
  a_r1_len_nonzero: assert property (@(posedge clk) disable iff (rst)
    push_v |-> (push_byte[LEN_W-1:0] != '0));

  // R3: the flush cycle after a limit tick needs a tick-free cycle
  a_r3_tick_gap: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/cirx_fifo.sv
module cirx_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   push,
  input  logic [W-1:0]           din,
  input  logic                   pop,
  input  logic                   flush,
  output logic                   full,
  output logic                   empty,
  output logic [$clog2(DEPTH):0] level,
  output logic [W-1:0]           head
);
  localparam int AW    = $clog2(DEPTH);
  localparam int LVL_W = AW + 1;
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr;
  logic [AW-1:0] rptr;
  logic          do_push;
  logic          do_pop;

  assign full    = (level == FULL_LVL);
  assign empty   = (level == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R7: a push into a full FIFO leaves it full and unchanged
  a_r7_full_holds: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> full);

  // R9: flush empties the FIFO
  a_r9_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);
endmodule

// File: rtl/cirx_status.sv
module cirx_status #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] ien,
  output logic [W-1:0] status,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= (status & ~clr) | set;
      irq    <= |(status & ien);
    end
  end

  // R5: a bit written with 1 and not set again reads 0 afterwards
  a_r5_w1c: assert property (@(posedge clk) disable iff (rst)
    (|(clr & ~set)) |=> ((status & $past(clr & ~set)) == '0));
endmodule

// File: rtl/cir_rx_sampler.sv
module cir_rx_sampler
  import cirx_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int LIMIT_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              ir_in,
  input  logic              tick_en,
  output logic              irq
);
  localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;
  localparam logic [LVL_W-1:0] TRIG1 = LVL_W'(1);
  localparam logic [LVL_W-1:0] TRIG2 = LVL_W'(FIFO_DEPTH / 4);
  localparam logic [LVL_W-1:0] TRIG3 = LVL_W'(FIFO_DEPTH / 2);
  localparam logic [LVL_W-1:0] TRIG4 = LVL_W'((3 * FIFO_DEPTH) / 4);

  logic [1:0]         ctrl_q;
  logic [7:0]         ien_q;
  logic [1:0]         trig_q;
  logic [LIMIT_W-1:0] limit_q;

  logic               push_v;
  logic [BYTE_W-1:0]  push_byte;
  logic               pkt_end;
  logic               full;
  logic               empty;
  logic [LVL_W-1:0]   level;
  logic [BYTE_W-1:0]  head;
  logic               flush;
  logic               pop;
  logic [LVL_W-1:0]   trig_lvl;
  logic [LVL_W-1:0]   level_inc;
  logic [7:0]         st_set;
  logic [7:0]         st_clr;
  logic [7:0]         status;

  assign flush     = reg_wr && (reg_addr == RG_FCTL) && reg_wdata[7];
  assign pop       = reg_rd && (reg_addr == RG_DATA);
  assign level_inc = level + 1'b1;
  assign st_clr    = (reg_wr && reg_addr == RG_STAT) ? reg_wdata : 8'h00;

  always_comb begin
    case (trig_q)
      2'd0:    trig_lvl = TRIG1;
      2'd1:    trig_lvl = TRIG2;
      2'd2:    trig_lvl = TRIG3;
      default: trig_lvl = TRIG4;
    endcase
  end

  always_comb begin
    st_set         = 8'h00;
    st_set[ST_RDR] = push_v && !flush;
    st_set[ST_RTR] = push_v && !flush && !full && (level_inc >= trig_lvl);
    st_set[ST_PE]  = pkt_end;
    st_set[ST_RFO] = push_v && !flush && full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      ien_q   <= '0;
      trig_q  <= '0;
      limit_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        RG_CTRL: ctrl_q <= reg_wdata[1:0];
        RG_IEN:  ien_q  <= reg_wdata;
        RG_FCTL: trig_q <= reg_wdata[1:0];
        RG_LIMH: limit_q[LIMIT_W-1:8] <= reg_wdata[LIMIT_W-9:0];
        RG_LIML: limit_q[7:0] <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        RG_CTRL:  reg_rdata <= {6'b0, ctrl_q};
        RG_STAT:  reg_rdata <= status;
        RG_IEN:   reg_rdata <= ien_q;
        RG_LEVEL: reg_rdata <= 8'(level);
        RG_DATA:  reg_rdata <= empty ? 8'h00 : head;
        RG_FCTL:  reg_rdata <= {6'b0, trig_q};
        RG_LIMH:  reg_rdata <= limit_q[LIMIT_W-1:8];
        default:  reg_rdata <= limit_q[7:0];
      endcase
    end
  end

  cirx_runlen #(.LIMIT_W(LIMIT_W), .LEN_W(LEN_W)) i_runlen (
    .clk(clk), .rst(rst), .en(ctrl_q[0]), .invert(ctrl_q[1]),
    .tick(tick_en), .ir_in(ir_in), .limit(limit_q),
    .push_v(push_v), .push_byte(push_byte), .pkt_end(pkt_end)
  );

  cirx_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) i_fifo (
    .clk(clk), .rst(rst), .push(push_v), .din(push_byte), .pop(pop),
    .flush(flush), .full(full), .empty(empty), .level(level), .head(head)
  );

  cirx_status #(.W(8)) i_status (
    .clk(clk), .rst(rst), .set(st_set), .clr(st_clr), .ien(ien_q),
    .status(status), .irq(irq)
  );

  // R7: overrun never appears without data ready
  a_r7_rfo_with_rdr: assert property (@(posedge clk) disable iff (rst)
    $rose(status[ST_RFO]) |-> status[ST_RDR]);

  // R6: no interrupt while every enable has been off for two cycles
  a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    (ien_q == '0 && $past(ien_q) == '0) |-> !irq);
endmodule

// File: tb/test_cir_rx_sampler.sv
module test_cir_rx_sampler;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ir_in = 1'b0;
  logic       tick_en = 1'b0;
  logic       irq;

  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  logic inv_tb = 1'b0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  cir_rx_sampler i_cir_rx_sampler (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ir_in(ir_in), .tick_en(tick_en), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic run(input logic pulse, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ir_in = pulse ^ inv_tb; tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  // expected bytes: full 127 chunks, then the remainder
  task automatic model(input logic pulse, input int n);
    int left = n;
    while (left > 127) begin
      exp_q.push_back({pulse, 7'h7F});
      left -= 127;
    end
    if (left > 0) exp_q.push_back({pulse, 7'(left)});
  endtask

  task automatic drain(input string tag);
    logic [7:0] v;
    rd(3'd3, v);
    chk({tag, " R8 level"}, v, exp_q.size());
    while (exp_q.size() > 0) begin
      rd(3'd4, v);
      chk({tag, " R1 byte"}, v, exp_q.pop_front());
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int plen[8] = '{1, 2, 126, 127, 128, 254, 255, 300};
    int llen[4] = '{1, 127, 128, 200};
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11: reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk($sformatf("R11 reg %0d", a), v, 0);
    end
    chk("R11 irq", irq, 0);

    // R8: empty read returns 0
    rd(3'd4, v);
    chk("R8 empty read", v, 0);

    // R1/R3: leading space ignored, mixed runs, limit 20
    wr(3'd7, 8'd20);
    wr(3'd0, 8'h01);
    run(0, 5); run(1, 5); run(0, 3); run(1, 130); run(0, 20);
    model(1, 5); model(0, 3); model(1, 130); model(0, 20);
    repeat (4) @(negedge clk);
    rd(3'd1, v);
    chk("R5 R3 R10 status after packet", v, 8'hE0);
    chk("R6 irq masked", irq, 0);
    drain("R3 pattern");

    // R6: interrupt follows enabled bits
    wr(3'd2, 8'h20);
    repeat (2) @(negedge clk);
    chk("R6 irq on packet end", irq, 1);
    wr(3'd1, 8'h20);
    repeat (2) @(negedge clk);
    chk("R6 irq after clear", irq, 0);
    rd(3'd1, v);
    chk("R5 only written bit cleared", v, 8'hC0);
    wr(3'd2, 8'h80);
    repeat (2) @(negedge clk);
    chk("R6 irq on data ready", irq, 1);
    wr(3'd2, 8'h00);
    repeat (2) @(negedge clk);
    chk("R6 irq disabled", irq, 0);
    wr(3'd1, 8'hFF);
    rd(3'd1, v);
    chk("R5 all cleared", v, 0);

    // R2/R3: sweep of pulse lengths and idle limits
    for (int k = 0; k < 8; k++) begin
      wr(3'd6, 8'(llen[k % 4] >> 8));
      wr(3'd7, 8'(llen[k % 4]));
      run(1, plen[k]); run(0, llen[k % 4]);
      model(1, plen[k]); model(0, llen[k % 4]);
      repeat (4) @(negedge clk);
      rd(3'd1, v);
      chk($sformatf("R3 packet end p=%0d", plen[k]), v[5], 1);
      drain($sformatf("R2 p=%0d l=%0d", plen[k], llen[k % 4]));
      wr(3'd1, 8'hFF);
    end

    // R4: inverted input
    wr(3'd6, 8'd0); wr(3'd7, 8'd10);
    wr(3'd0, 8'h03);
    inv_tb = 1'b1;
    run(0, 4); run(1, 6); run(0, 10);
    model(1, 6); model(0, 10);
    repeat (4) @(negedge clk);
    drain("R4 invert");
    inv_tb = 1'b0;
    wr(3'd0, 8'h00);
    wr(3'd1, 8'hFF);

    // R3: limit 0 never ends a packet
    wr(3'd7, 8'd0);
    wr(3'd0, 8'h01);
    run(1, 3); run(0, 300);
    model(1, 3); model(0, 254);
    repeat (4) @(negedge clk);
    rd(3'd1, v);
    chk("R3 limit zero no packet end", v[5], 0);
    drain("R3 limit zero");

    // R4: disabled sampling ignores ticks
    wr(3'd0, 8'h00);
    run(1, 10); run(0, 10);
    rd(3'd3, v);
    chk("R4 disabled no bytes", v, 0);

    // R9/R7: trigger level 8 and overrun
    wr(3'd5, 8'h01);
    wr(3'd1, 8'hFF);
    wr(3'd0, 8'h01);
    for (int i = 0; i < 8; i++) run(1'(i % 2 == 0), 1);
    rd(3'd3, v);
    chk("R9 seven bytes", v, 7);
    rd(3'd1, v);
    chk("R9 below trigger", v[6], 0);
    run(1'b1, 1);
    rd(3'd1, v);
    chk("R9 trigger reached", v[6], 1);
    chk("R7 no overrun yet", v[4], 0);
    for (int i = 0; i < 30; i++) run(1'(i % 2 == 1), 1);
    rd(3'd3, v);
    chk("R7 level saturates", v, 32);
    rd(3'd1, v);
    chk("R7 overrun and ready", v & 8'h90, 8'h90);
    rd(3'd4, v);
    chk("R7 oldest byte kept", v, 8'h81);
    wr(3'd5, 8'h81);
    rd(3'd3, v);
    chk("R9 flush empties", v, 0);
    rd(3'd5, v);
    chk("R9 control readback", v, 8'h01);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end
endmodule